// File: doc/BRIEF.md
# Cascaded Octet-Stage Next-Hop Classifier

This block is a pipelined inference engine that turns a 32-bit destination address into one of eight output ports. The address is cut into four 8-bit slices, most significant slice first. Each slice drives its own small two-layer feed-forward network. Every network also takes in the hard-limited 8-wide output of the network before it, so only the last stage names the port. All inputs are bipolar. Each stage output is rounded to a single bit, so the whole datapath stays in integer logic and no network needs a true multiplier.

The weights are computed off-chip. They are loaded through a flat word-addressed write port, normally while no lookups are in flight. A new address can be presented on every clock. Each result comes out a fixed number of cycles later with a valid strobe, together with the final 8-bit vote vector, the chosen port and a miss flag.

Top module: `ocnh_classifier`

## Requirements
- R1: A synchronous active-low reset clears the pipeline and every weight to zero. While reset is held and in the first cycle after it, out_valid is 0. With all weights zero, every output sum is exactly 0, so a lookup returns out_vec = 8'hFF and port 0.
- R2: Stage s (0..3) reads address bits [31-8s : 24-8s]. Its input index i (1..8) is octet bit i-1. A 1 bit counts as +1 and a 0 bit counts as -1.
- R3: Input indices 9..16 of stage s are output bits 0..7 of stage s-1, in the same bipolar encoding. Stage 0 sees all eight of these inputs as -1.
- R4: Hidden neuron j forms acc = w[j][0] + sum over i of (+w[j][i] or -w[j][i]). It saturates acc to 24-bit signed. It then maps acc to a level: +2 if acc >= 256, +1 if acc >= 64, 0 if acc > -64, -1 if acc > -256, and -2 otherwise.
- R5: Output neuron o forms pre = 2*v[o][0] + sum over j of v[o][j+1]*level[j], saturated to 24-bit signed. Its output bit is 1 (meaning +1) exactly when pre >= 0.
- R6: Weights are 16-bit signed words. Word address = s*STAGE_WORDS + offset, where STAGE_WORDS = 17*N_HID + 8*(N_HID+1). Hidden weight w[j][i] sits at offset j*17+i. Output weight v[o][k] sits at offset 17*N_HID + o*(N_HID+1) + k. Index 0 is the bias in both layers.
- R7: out_port is the lowest index whose bit in out_vec is 1. When out_vec is zero, out_miss is 1 and out_port is 0.
- R8: One address can be accepted every clock. A result appears 9 clock edges after its address is sampled, counting the sampling edge. Idle input cycles produce no out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Address strobe |
| in_addr | input | 32 | Destination address |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | 11 | Flat weight word address |
| wr_data | input | 16 | Signed weight word |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 8 | Final stage output bits |
| out_port | output | 3 | Selected port |
| out_miss | output | 1 | No output bit set |

## Verification
The assertions check, on every cycle, that the port decode agrees with the final vote vector. This covers the lowest-set-bit choice and the miss case. They also check that the result strobe trails the input strobe by exactly the pipeline depth and that reset silences the output. What only the scenarios can show is whether the arithmetic is right. That means the octet order, the bipolar sign of each input, the chaining between stages, the five-level activation, the sign convention at exactly zero and the weight address map. The bench reaches these by comparing the vote vectors with a reference model, both under random weight sets and under directed bias settings.

// File: rtl/ocnh_pkg.sv
// Package: shared arithmetic widths and helper functions for the classifier.
// Assumes 16-bit signed weights and a 24-bit signed saturating accumulator.
package ocnh_pkg;
    localparam int ACC_W  = 24;
    localparam int SUM_W  = 32;
    localparam int LVL_W  = 3;
    localparam int ACT_HI = 256;
    localparam int ACT_LO = 64;

    // Clamp a wide sum into the signed accumulator range.
    function automatic logic signed [ACC_W-1:0] sat_acc(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] hi;
        logic signed [SUM_W-1:0] lo;
        hi = SUM_W'((2 ** (ACC_W-1)) - 1);
        lo = -hi - SUM_W'(1);
        if (v > hi)      return hi[ACC_W-1:0];
        else if (v < lo) return lo[ACC_W-1:0];
        else             return v[ACC_W-1:0];
    endfunction

    // Five-step bipolar squashing: levels -2..+2 stand for -1.0..+1.0.
    function automatic logic signed [LVL_W-1:0] act_level(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] thi;
        logic signed [ACC_W-1:0] tlo;
        thi = ACC_W'(ACT_HI);
        tlo = ACC_W'(ACT_LO);
        if (a >= thi)      return LVL_W'(2);
        else if (a >= tlo) return LVL_W'(1);
        else if (a > -tlo) return LVL_W'(0);
        else if (a > -thi) return -LVL_W'(1);
        else               return -LVL_W'(2);
    endfunction
endpackage

// File: rtl/ocnh_hidden_layer.sv
// Hidden layer of one stage: bipolar inputs, add/subtract of weights, level quantise.
// Assumes input x[i] pairs with weight index i+1; index 0 of each row is the bias.
module ocnh_hidden_layer
    import ocnh_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_HID  = 10,
    parameter int W_W    = 16,
    parameter int ADDR_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [ADDR_W-1:0]              in_addr,
    input  logic [N_IN-1:0]                x,
    input  logic [N_HID*(N_IN+1)*W_W-1:0]  w_flat,
    output logic                           out_valid,
    output logic [ADDR_W-1:0]              out_addr,
    output logic [N_HID*LVL_W-1:0]         lvl
);
    localparam int ROW = N_IN + 1;

    logic signed [SUM_W-1:0] sum_c [N_HID];
    logic [N_HID*LVL_W-1:0]  lvl_c;

    // Accumulate bias plus signed weights, then quantise each neuron.
    always_comb begin
        for (int j = 0; j < N_HID; j++) begin
            sum_c[j] = SUM_W'(signed'(w_flat[(j*ROW)*W_W +: W_W]));
            for (int i = 0; i < N_IN; i++) begin
                if (x[i]) sum_c[j] = sum_c[j] + SUM_W'(signed'(w_flat[(j*ROW+i+1)*W_W +: W_W]));
                else      sum_c[j] = sum_c[j] - SUM_W'(signed'(w_flat[(j*ROW+i+1)*W_W +: W_W]));
            end
            lvl_c[j*LVL_W +: LVL_W] = act_level(sat_acc(sum_c[j]));
        end
    end

    // Pipeline register for levels, strobe and carried address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            lvl       <= '0;
        end else begin
            out_valid <= in_valid;
            out_addr  <= in_addr;
            lvl       <= lvl_c;
        end
    end
endmodule

// File: rtl/ocnh_output_layer.sv
// Output layer of one stage: weighted sum of hidden levels, hard limit to one bit.
// Assumes levels in -2..+2 scale 1.0 as 2, so the bias is doubled to match.
module ocnh_output_layer
    import ocnh_pkg::*;
#(
    parameter int N_HID  = 10,
    parameter int N_OUT  = 8,
    parameter int W_W    = 16,
    parameter int ADDR_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [ADDR_W-1:0]               in_addr,
    input  logic [N_HID*LVL_W-1:0]          lvl,
    input  logic [N_OUT*(N_HID+1)*W_W-1:0]  w_flat,
    output logic                            out_valid,
    output logic [ADDR_W-1:0]               out_addr,
    output logic [N_OUT-1:0]                bits
);
    localparam int ROW = N_HID + 1;

    logic signed [SUM_W-1:0] pre_c [N_OUT];
    logic [N_OUT-1:0]        bits_c;

    // Doubled bias plus level-weighted products; sign gives the output bit.
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            pre_c[o] = SUM_W'(signed'(w_flat[(o*ROW)*W_W +: W_W])) <<< 1;
            for (int j = 0; j < N_HID; j++) begin
                pre_c[o] = pre_c[o]
                         + SUM_W'(signed'(w_flat[(o*ROW+j+1)*W_W +: W_W]))
                         * SUM_W'(signed'(lvl[j*LVL_W +: LVL_W]));
            end
            bits_c[o] = !sat_acc(pre_c[o])[ACC_W-1];
        end
    end

    // Pipeline register for the stage output bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            bits      <= '0;
        end else begin
            out_valid <= in_valid;
            out_addr  <= in_addr;
            bits      <= bits_c;
        end
    end
endmodule

// File: rtl/ocnh_stage.sv
// One octet stage: weight store, hidden layer and output layer, two cycles deep.
// Assumes the stage owns flat weight words BASE .. BASE+STAGE_WORDS-1.
module ocnh_stage #(
    parameter int STAGE_IDX = 0,
    parameter int ADDR_W    = 32,
    parameter int OCT_W     = 8,
    parameter int N_OUT     = 8,
    parameter int N_HID     = 10,
    parameter int W_W       = 16,
    parameter int WADDR_W   = 11,
    parameter int BASE      = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [W_W-1:0]     wr_data,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [N_OUT-1:0]   in_chain,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [N_OUT-1:0]   out_chain
);
    import ocnh_pkg::LVL_W;

    localparam int N_IN      = OCT_W + N_OUT;
    localparam int HID_WORDS = N_HID * (N_IN + 1);
    localparam int OUT_WORDS = N_OUT * (N_HID + 1);
    localparam int OCT_LSB   = ADDR_W - OCT_W * (STAGE_IDX + 1);

    logic [HID_WORDS*W_W-1:0] hid_w;
    logic [OUT_WORDS*W_W-1:0] out_w;
    logic [N_IN-1:0]          x;
    logic                     mid_valid;
    logic [ADDR_W-1:0]        mid_addr;
    logic [N_HID*LVL_W-1:0]   mid_lvl;

    // Capture weight words addressed to this stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hid_w <= '0;
            out_w <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < HID_WORDS; k++)
                if (wr_addr == WADDR_W'(BASE + k)) hid_w[k*W_W +: W_W] <= wr_data;
            for (int k = 0; k < OUT_WORDS; k++)
                if (wr_addr == WADDR_W'(BASE + HID_WORDS + k)) out_w[k*W_W +: W_W] <= wr_data;
        end
    end

    assign x = {in_chain, in_addr[OCT_LSB +: OCT_W]};

    ocnh_hidden_layer #(
        .N_IN(N_IN), .N_HID(N_HID), .W_W(W_W), .ADDR_W(ADDR_W)
    ) u_hid (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_addr(in_addr), .x(x), .w_flat(hid_w),
        .out_valid(mid_valid), .out_addr(mid_addr), .lvl(mid_lvl)
    );

    ocnh_output_layer #(
        .N_HID(N_HID), .N_OUT(N_OUT), .W_W(W_W), .ADDR_W(ADDR_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(mid_valid), .in_addr(mid_addr), .lvl(mid_lvl), .w_flat(out_w),
        .out_valid(out_valid), .out_addr(out_addr), .bits(out_chain)
    );
endmodule

// File: rtl/ocnh_port_decode.sv
// Final decode: lowest set bit of the last stage vector selects the port.
// Assumes an all-zero vector means no port voted; the port then reads 0.
module ocnh_port_decode #(
    parameter int N_OUT  = 8,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_OUT-1:0]  in_vec,
    output logic              out_valid,
    output logic [N_OUT-1:0]  out_vec,
    output logic [PORT_W-1:0] out_port,
    output logic              out_miss
);
    logic [PORT_W-1:0] port_c;
    logic              hit_c;

    // Priority scan from the top so the lowest set index wins.
    always_comb begin
        port_c = '0;
        hit_c  = 1'b0;
        for (int o = N_OUT - 1; o >= 0; o--) begin
            if (in_vec[o]) begin
                port_c = PORT_W'(o);
                hit_c  = 1'b1;
            end
        end
    end

    // Register the decoded result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            out_port  <= '0;
            out_miss  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_vec   <= in_vec;
            out_port  <= port_c;
            out_miss  <= !hit_c;
        end
    end
endmodule

// File: rtl/ocnh_classifier.sv
// Top: four cascaded octet stages followed by the port decode.
// Assumes weights are loaded while no lookup is in flight; latency is 2*stages+1.
module ocnh_classifier #(
    parameter int ADDR_W  = 32,
    parameter int OCT_W   = 8,
    parameter int N_OUT   = 8,
    parameter int N_HID   = 10,
    parameter int W_W     = 16,
    parameter int PORT_W  = $clog2(N_OUT),
    parameter int WADDR_W = $clog2((ADDR_W / OCT_W) *
                                   (N_HID * (OCT_W + N_OUT + 1) + N_OUT * (N_HID + 1)))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [W_W-1:0]     wr_data,
    output logic               out_valid,
    output logic [N_OUT-1:0]   out_vec,
    output logic [PORT_W-1:0]  out_port,
    output logic               out_miss
);
    localparam int N_STAGE     = ADDR_W / OCT_W;
    localparam int STAGE_WORDS = N_HID * (OCT_W + N_OUT + 1) + N_OUT * (N_HID + 1);

    logic [N_STAGE:0]  v_ch;
    logic [ADDR_W-1:0] a_ch [N_STAGE+1];
    logic [N_OUT-1:0]  c_ch [N_STAGE+1];

    assign v_ch[0] = in_valid;
    assign a_ch[0] = in_addr;
    assign c_ch[0] = '0;

    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        ocnh_stage #(
            .STAGE_IDX(s), .ADDR_W(ADDR_W), .OCT_W(OCT_W), .N_OUT(N_OUT),
            .N_HID(N_HID), .W_W(W_W), .WADDR_W(WADDR_W), .BASE(s * STAGE_WORDS)
        ) u_stage (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
            .in_valid(v_ch[s]), .in_addr(a_ch[s]), .in_chain(c_ch[s]),
            .out_valid(v_ch[s+1]), .out_addr(a_ch[s+1]), .out_chain(c_ch[s+1])
        );
    end

    ocnh_port_decode #(.N_OUT(N_OUT), .PORT_W(PORT_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .in_valid(v_ch[N_STAGE]), .in_vec(c_ch[N_STAGE]),
        .out_valid(out_valid), .out_vec(out_vec), .out_port(out_port), .out_miss(out_miss)
    );
endmodule

// File: rtl/ocnh_classifier_chk.sv
// Checker: decode consistency, fixed latency and reset quiet on the top ports.
// Assumes the latency equals 2*stages+1 edges, tracked with a local shift register.
module ocnh_classifier_chk #(
    parameter int ADDR_W = 32,
    parameter int OCT_W  = 8,
    parameter int N_OUT  = 8,
    parameter int PORT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [N_OUT-1:0]  out_vec,
    input logic [PORT_W-1:0] out_port,
    input logic              out_miss
);
    localparam int LAT = 2 * (ADDR_W / OCT_W) + 1;

    logic [LAT-1:0] vhist;

    // Independent record of past input strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) vhist <= '0;
        else        vhist <= {vhist[LAT-2:0], in_valid};
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    assert_miss_means_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_miss) |-> (out_vec == '0 && out_port == '0));

    assert_port_first_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_miss) |->
        (out_vec[out_port] && ((out_vec & ((N_OUT'(1) << out_port) - N_OUT'(1))) == '0)));

    assert_fixed_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vhist[LAT-1]);

    assert_known_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown({out_vec, out_port, out_miss}));
endmodule

bind ocnh_classifier ocnh_classifier_chk #(
    .ADDR_W(ADDR_W), .OCT_W(OCT_W), .N_OUT(N_OUT), .PORT_W(PORT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_vec(out_vec), .out_port(out_port), .out_miss(out_miss)
);

// File: tb/sim_ocnh_classifier.sv
// Scoreboard bench: driver pushes model results, monitor pops on out_valid.
module sim_ocnh_classifier;
    localparam int N_HID = 10;
    localparam int ROWH  = 17;
    localparam int ROWO  = N_HID + 1;
    localparam int HIDW  = N_HID * ROWH;
    localparam int STW   = HIDW + 8 * ROWO;
    localparam int WA    = 11;
    localparam int LAT   = 9;
    localparam int SATP  = 8388607;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic wr_en = 1'b0;
    logic [WA-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic out_valid;
    logic [7:0] out_vec;
    logic [2:0] out_port;
    logic out_miss;

    always #5 clk = ~clk;

    ocnh_classifier #(.N_HID(N_HID)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_vec(out_vec), .out_port(out_port), .out_miss(out_miss)
    );

    typedef struct { logic [7:0] vec; int t; string tag; } exp_t;
    exp_t q[$];
    int wm [4][STW];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int clampv(input int v);
        if (v > SATP) return SATP;
        if (v < -SATP - 1) return -SATP - 1;
        return v;
    endfunction

    function automatic int lvl_of(input int a);
        if (a >= 256) return 2;
        if (a >= 64) return 1;
        if (a > -64) return 0;
        if (a > -256) return -1;
        return -2;
    endfunction

    // Reference model built from R2..R6.
    function automatic logic [7:0] ref_vec(input logic [31:0] a);
        logic [7:0] ch;
        logic [7:0] nx;
        ch = 8'h00;
        for (int s = 0; s < 4; s++) begin
            int lv [N_HID];
            for (int j = 0; j < N_HID; j++) begin
                int acc;
                acc = wm[s][j*ROWH];
                for (int i = 0; i < 16; i++) begin
                    logic b;
                    b = (i < 8) ? a[24 - 8*s + i] : ch[i-8];
                    acc = b ? acc + wm[s][j*ROWH+1+i] : acc - wm[s][j*ROWH+1+i];
                end
                lv[j] = lvl_of(clampv(acc));
            end
            for (int o = 0; o < 8; o++) begin
                int p;
                p = 2 * wm[s][HIDW + o*ROWO];
                for (int j = 0; j < N_HID; j++) p += wm[s][HIDW + o*ROWO + 1 + j] * lv[j];
                nx[o] = (clampv(p) >= 0);
            end
            ch = nx;
        end
        return ch;
    endfunction

    task automatic wr_w(input int s, input int off, input int val);
        wr_en   = 1'b1;
        wr_addr = WA'(s * STW + off);
        wr_data = 16'(val);
        wm[s][off] = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [31:0] a, input bit v, input string tag);
        exp_t e;
        in_valid = v;
        in_addr  = a;
        if (v) begin
            e.vec = ref_vec(a);
            e.t   = cyc;
            e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (LAT + 3) @(negedge clk);
    endtask

    // Monitor: compare each result with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            exp_t e;
            logic [2:0] ep;
            logic em;
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected result: actual vec=%h expected none", out_vec);
            end else begin
                e = q.pop_front();
                em = (e.vec == 8'h00);
                ep = 3'd0;
                for (int o = 7; o >= 0; o--) if (e.vec[o]) ep = 3'(o);
                if (out_vec !== e.vec) begin
                    n_bad++;
                    $display("FAIL %s vec: actual %h expected %h", e.tag, out_vec, e.vec);
                end else if (out_port !== ep || out_miss !== em) begin
                    n_bad++;
                    $display("FAIL R7 port/miss: actual %0d/%0b expected %0d/%0b",
                             out_port, out_miss, ep, em);
                end else if (cyc - e.t != LAT) begin
                    n_bad++;
                    $display("FAIL R8 latency: actual %0d expected %0d", cyc - e.t, LAT);
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int s = 0; s < 4; s++) for (int k = 0; k < STW; k++) wm[s][k] = 0;
        repeat (3) @(negedge clk);
        // R1: held in reset, output quiet
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset valid: actual %b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || out_vec !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 after reset: actual %b/%h expected 0/00", out_valid, out_vec);
        end

        // R1 and R5: zero weights give sums of exactly 0, so every bit is +1
        send(32'h0000_0000, 1'b1, "R1");
        send(32'hFFFF_FFFF, 1'b1, "R1");
        send(32'hC0A8_1201, 1'b1, "R5");
        drain();

        // R7: last stage output biases negative, so nothing votes and the lookup misses
        for (int o = 0; o < 8; o++) wr_w(3, HIDW + o*ROWO, -1);
        send(32'h0A00_0001, 1'b1, "R7");
        send(32'h1234_5678, 1'b1, "R7");
        drain();

        // R7: bits 5 and 6 vote, so the lowest one (5) is chosen
        wr_w(3, HIDW + 5*ROWO, 1);
        wr_w(3, HIDW + 6*ROWO, 1);
        send(32'h0101_0101, 1'b1, "R7");
        drain();
        // R7: only the top bit votes
        wr_w(3, HIDW + 5*ROWO, -1);
        wr_w(3, HIDW + 6*ROWO, -1);
        wr_w(3, HIDW + 7*ROWO, 3);
        send(32'h8000_0000, 1'b1, "R7");
        drain();

        // R2, R3, R4 and R6: random weight sets, back-to-back addresses with bubbles
        for (int round = 0; round < 3; round++) begin
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < STW; k++)
                    wr_w(s, k, int'($urandom_range(0, 255)) - 128);
            send(32'h0000_0000, 1'b1, "R2/R3/R4/R6");
            send(32'hFFFF_FFFF, 1'b1, "R2/R3/R4/R6");
            for (int n = 0; n < 60; n++)
                send($urandom, ($urandom_range(0, 3) != 0), "R2/R3/R4/R6/R8");
            drain();
        end

        // R8: every pushed item must have come out
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R8 leftover: actual %0d expected 0", q.size());
        end
        done = 1'b1;
        summary();
    end
endmodule